// File: doc/BRIEF.md
# Multi-Stage Per-Core Watchdog Bank

This block holds one watchdog timer for each processor core. Every timer counts down a programmed period. If software fails to service the timer before the period ends, the timer escalates by one stage. The first expiry raises the core's interrupt. The next expiry raises the core's non-maskable interrupt. The expiry after that requests a soft reset of the whole chip. A mode field chooses how far each timer may escalate.

Software reaches the bank through a flat register space with two registers per core. The setup register sits at the even address `2*core` and holds the period length, the mode and a read-only stage number. The service register sits at the odd address `2*core+1`. Writing the value 1 to it reloads the timer and clears its escalation.

The period length is the upper part of a down-counter with `LEN_W + LOW_W` bits. That counter steps once on every wrap of a `PRE_W`-bit clock prescaler. One period therefore lasts `(len+1) * 2^(LOW_W+PRE_W)` clocks. With the default parameters this reaches 2^32 clocks. When the chip reset fires, every timer returns to the disabled state.

Each core's escalation is a state machine with five states:

| State | Stage number | Meaning |
|-------|--------------|---------|
| ST_OFF | 0 | Disabled |
| ST_ARMED | 0 | Counting toward the first expiry |
| ST_IRQ | 1 | Interrupt raised |
| ST_NMI | 2 | Interrupt and NMI raised |
| ST_RESET | 3 | Chip-wide reset being requested |

The transitions are checked in the following priority order:
- **Reset sweep:** any state goes to ST_OFF when the chip soft reset fires.
- **Setup write:** any state goes to ST_ARMED if the new mode is nonzero, and to ST_OFF if it is zero.
- **Service:** any state goes to ST_ARMED if the mode is nonzero, and to ST_OFF if it is zero.
- **Escalation:** on an expiry, ST_ARMED goes to ST_IRQ, ST_IRQ goes to ST_NMI and ST_NMI goes to ST_RESET. An escalation is only taken when the mode enables the next stage.

Top module: `core_watchdog_bank`

## Requirements
- R1: After reset, every interrupt output, every NMI output and the soft-reset output are low, and every setup register reads 0.
- R2: With a nonzero mode, a core's interrupt output rises exactly `(len+1)*2^(LOW_W+PRE_W)` clocks after the clock edge that takes the setup write or service, and not one clock earlier. The interrupt output is a level.
- R3: With mode 2 or 3 and no service, the NMI output rises exactly one period after the interrupt output rises.
- R4: With mode 3 and no service, the soft-reset output pulses high for exactly one clock, one period after the NMI rises. In that clock the setup register reads stage 3. On the following clock, every core's setup register reads 0 and all interrupt and NMI outputs are low.
- R5: Mode 1 raises only the interrupt output, and the stage then holds at 1. Mode 2 raises the interrupt and then the NMI, and the stage then holds at 2. Neither mode ever produces a soft reset.
- R6: Writing all zeros to a setup register disables that core at once. Its outputs drop or stay low, and the core never expires.
- R7: Writing exactly 1 to a service register drops that core's interrupt and NMI outputs and restarts a full period. Any other written value has no effect.
- R8: Each core's timer, outputs and service register are independent of every other core's.
- R9: A setup register reads back length in bits [15:0], mode in bits [17:16] and stage in bits [19:18], with all other bits 0. A service address reads as 0.
- R10: A setup write restarts both the prescaler and the down-counter, so the next expiry is one full period after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: `{core, 0}` selects the setup register, `{core, 1}` selects the service register |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address, same layout as `wr_addr` |
| rd_data | output | DATA_W | Combinational read data |
| irq_o | output | NUM_CORES | Per-core interrupt level |
| nmi_o | output | NUM_CORES | Per-core non-maskable interrupt level |
| soft_rst_o | output | 1 | Chip soft-reset request, one-clock pulse |

## Verification
The escalation path is exercised with each mode value:
- Mode 3 runs through the whole chain to the reset pulse.
- Mode 1 and mode 2 show where escalation stops and that the stage then holds.
- Mode 0 shows an immediate disable.

Each edge is sampled one clock before and on the cycle it is due, which separates an exact period from an off-by-one prescaler or reload. Services are written with the values 0, 3 and 1, which tells an exact-match decode apart from a single-bit decode. Service writes and rewrites of the setup register are placed mid-period, which shows whether the prescaler really restarts. Two cores run overlapping periods of different lengths, and one is serviced while the other keeps counting, which exposes any crosstalk between cores.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ARMED = 3'd1,
        ST_IRQ   = 3'd2,
        ST_NMI   = 3'd3,
        ST_RESET = 3'd4
    } wdt_state_e;

    localparam logic [1:0] MODE_OFF      = 2'd0;
    localparam logic [1:0] MODE_IRQ      = 2'd1;
    localparam logic [1:0] MODE_IRQ_NMI  = 2'd2;
    localparam logic [1:0] MODE_FULL     = 2'd3;

    function automatic logic [1:0] stage_of(input wdt_state_e st);
        case (st)
            ST_IRQ:   stage_of = 2'd1;
            ST_NMI:   stage_of = 2'd2;
            ST_RESET: stage_of = 2'd3;
            default:  stage_of = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int LEN_W = 16,
    parameter int LOW_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             run_i,
    output logic             expire_o
);
    localparam int CNT_W = LEN_W + LOW_W;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             pre_wrap;

    assign load_val = {len_i, {LOW_W{1'b1}}};
    assign pre_wrap = &pre_q;
    assign expire_o = run_i && pre_wrap && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (restart_i) begin
            pre_q <= '0;
            cnt_q <= load_val;
        end else if (run_i) begin
            pre_q <= pre_q + 1'b1;
            if (pre_wrap) begin
                if (cnt_q == '0) begin
                    cnt_q <= load_val;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R2: the decrementer only moves on a prescaler wrap
    assert_step_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && !pre_wrap) |=> $stable(cnt_q));

    // R5: a stopped timer holds its count
    assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> ($stable(cnt_q) && $stable(pre_q)));

endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_all_i,
    input  logic       cfg_wr_i,
    input  logic [1:0] new_mode_i,
    input  logic       poke_i,
    input  logic [1:0] mode_i,
    input  logic       expire_i,
    output wdt_state_e state_o,
    output logic       run_o,
    output logic       irq_o,
    output logic       nmi_o,
    output logic       rst_req_o
);
    wdt_state_e state_q;
    wdt_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clear_all_i) begin
            state_d = ST_OFF;
        end else if (cfg_wr_i) begin
            state_d = (new_mode_i == MODE_OFF) ? ST_OFF : ST_ARMED;
        end else if (poke_i) begin
            state_d = (mode_i == MODE_OFF) ? ST_OFF : ST_ARMED;
        end else if (expire_i) begin
            unique case (state_q)
                ST_ARMED: state_d = ST_IRQ;
                ST_IRQ:   state_d = ST_NMI;
                ST_NMI:   state_d = ST_RESET;
                ST_OFF:   state_d = ST_OFF;
                ST_RESET: state_d = ST_RESET;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        run_o     = 1'b0;
        irq_o     = 1'b0;
        nmi_o     = 1'b0;
        rst_req_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_ARMED: begin
                run_o = (mode_i != MODE_OFF);
            end
            ST_IRQ: begin
                irq_o = 1'b1;
                run_o = (mode_i == MODE_IRQ_NMI) || (mode_i == MODE_FULL);
            end
            ST_NMI: begin
                irq_o = 1'b1;
                nmi_o = 1'b1;
                run_o = (mode_i == MODE_FULL);
            end
            ST_RESET: begin
                irq_o     = 1'b1;
                nmi_o     = 1'b1;
                rst_req_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign state_o = state_q;

    // R2: the interrupt only rises after an expiry
    assert_irq_from_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(expire_i));

    // R3: the NMI only follows an interrupt already raised
    assert_nmi_after_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(irq_o));

    // R5: mode 1 never reaches the NMI stage
    assert_mode1_no_nmi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_IRQ) |-> !nmi_o);

    // R7: a service always drops the interrupt
    assert_poke_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poke_i |=> !irq_o);

    // R4: a reset request only comes from mode 3
    assert_reset_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(mode_i == MODE_FULL));

endmodule

// File: rtl/wdt_core_timer.sv
module wdt_core_timer
    import wdt_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int LOW_W  = 8,
    parameter int PRE_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all_i,
    input  logic              cfg_wr_i,
    input  logic [LEN_W-1:0]  wr_len_i,
    input  logic [1:0]        wr_mode_i,
    input  logic              poke_i,
    output logic [DATA_W-1:0] cfg_rd_o,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              rst_req_o
);
    localparam int REG_W = LEN_W + 4;

    logic [LEN_W-1:0] len_q;
    logic [1:0]       mode_q;
    logic [LEN_W-1:0] cur_len;
    logic             restart;
    logic             run;
    logic             expire;
    wdt_state_e       state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            mode_q <= MODE_OFF;
        end else if (clear_all_i) begin
            len_q  <= '0;
            mode_q <= MODE_OFF;
        end else if (cfg_wr_i) begin
            len_q  <= wr_len_i;
            mode_q <= wr_mode_i;
        end
    end

    assign cur_len = cfg_wr_i ? wr_len_i : len_q;
    assign restart = clear_all_i || cfg_wr_i || poke_i;

    wdt_countdown #(
        .LEN_W (LEN_W),
        .LOW_W (LOW_W),
        .PRE_W (PRE_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .len_i     (cur_len),
        .run_i     (run),
        .expire_o  (expire)
    );

    wdt_stage_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_all_i (clear_all_i),
        .cfg_wr_i    (cfg_wr_i),
        .new_mode_i  (wr_mode_i),
        .poke_i      (poke_i),
        .mode_i      (mode_q),
        .expire_i    (expire),
        .state_o     (state),
        .run_o       (run),
        .irq_o       (irq_o),
        .nmi_o       (nmi_o),
        .rst_req_o   (rst_req_o)
    );

    assign cfg_rd_o = DATA_W'({stage_of(state), mode_q, len_q});

    // R6: a disabled core never shows an interrupt
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !clear_all_i && wr_mode_i == MODE_OFF) |=> (!irq_o && !nmi_o));

    initial begin
        assert_reg_fits_R9: assert (REG_W <= DATA_W);
    end

endmodule

// File: rtl/wdt_regif.sv
module wdt_regif #(
    parameter int NUM_CORES = 4,
    parameter int LEN_W     = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_CORES-1:0][DATA_W-1:0] cfg_rd_i,
    output logic [NUM_CORES-1:0]             cfg_wr_o,
    output logic [NUM_CORES-1:0]             poke_o,
    output logic [LEN_W-1:0]                 wr_len_o,
    output logic [1:0]                       wr_mode_o,
    output logic [DATA_W-1:0]                rd_data
);
    logic poke_val;

    assign wr_len_o  = wr_data[LEN_W-1:0];
    assign wr_mode_o = wr_data[LEN_W+1:LEN_W];
    assign poke_val  = (wr_data == DATA_W'(1));

    always_comb begin
        cfg_wr_o = '0;
        poke_o   = '0;
        rd_data  = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (wr_en && wr_addr == ADDR_W'(2 * i)) begin
                cfg_wr_o[i] = 1'b1;
            end
            if (wr_en && poke_val && wr_addr == ADDR_W'(2 * i + 1)) begin
                poke_o[i] = 1'b1;
            end
            if (rd_addr == ADDR_W'(2 * i)) begin
                rd_data = cfg_rd_i[i];
            end
        end
    end

endmodule

// File: rtl/core_watchdog_bank.sv
module core_watchdog_bank #(
    parameter int NUM_CORES = 4,
    parameter int LEN_W     = 16,
    parameter int LOW_W     = 8,
    parameter int PRE_W     = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = $clog2(NUM_CORES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_CORES-1:0] irq_o,
    output logic [NUM_CORES-1:0] nmi_o,
    output logic                 soft_rst_o
);
    logic [NUM_CORES-1:0][DATA_W-1:0] cfg_rd;
    logic [NUM_CORES-1:0]             cfg_wr;
    logic [NUM_CORES-1:0]             poke;
    logic [NUM_CORES-1:0]             rst_req;
    logic [LEN_W-1:0]                 wr_len;
    logic [1:0]                       wr_mode;

    wdt_regif #(
        .NUM_CORES (NUM_CORES),
        .LEN_W     (LEN_W),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regif (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .cfg_rd_i  (cfg_rd),
        .cfg_wr_o  (cfg_wr),
        .poke_o    (poke),
        .wr_len_o  (wr_len),
        .wr_mode_o (wr_mode),
        .rd_data   (rd_data)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        wdt_core_timer #(
            .LEN_W  (LEN_W),
            .LOW_W  (LOW_W),
            .PRE_W  (PRE_W),
            .DATA_W (DATA_W)
        ) u_timer (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear_all_i (soft_rst_o),
            .cfg_wr_i    (cfg_wr[c]),
            .wr_len_i    (wr_len),
            .wr_mode_i   (wr_mode),
            .poke_i      (poke[c]),
            .cfg_rd_o    (cfg_rd[c]),
            .irq_o       (irq_o[c]),
            .nmi_o       (nmi_o[c]),
            .rst_req_o   (rst_req[c])
        );
    end

    assign soft_rst_o = |rst_req;

    // R4: the chip reset request lasts a single clock
    assert_reset_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R4: the reset sweep leaves every core quiet
    assert_reset_clears_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (irq_o == '0 && nmi_o == '0));

    // R1: nothing is raised in the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_o == '0 && !soft_rst_o));

endmodule

// File: tb/core_watchdog_bank_tb_top.sv
`timescale 1ns/100ps
module core_watchdog_bank_tb_top;
    localparam int NC = 4;
    localparam int AW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NC-1:0] irq_o;
    logic [NC-1:0] nmi_o;
    logic          soft_rst_o;

    core_watchdog_bank #(
        .NUM_CORES (NC),
        .LEN_W     (16),
        .LOW_W     (2),
        .PRE_W     (2),
        .DATA_W    (DW)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq_o      (irq_o),
        .nmi_o      (nmi_o),
        .soft_rst_o (soft_rst_o)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // kinds: 0 irq, 1 nmi, 2 soft reset, 3 setup register of core, 4 raw read address
    typedef struct {
        int          at;
        int          kind;
        int          core;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    function automatic logic [31:0] cfg(input int len, input int mode, input int stage = 0);
        return (32'(stage) << 18) | (32'(mode) << 16) | 32'(len);
    endfunction

    task automatic push(input int at, input int kind, input int core, input logic [31:0] val,
                        input string tag);
        exp_t e;
        e.at = at; e.kind = kind; e.core = core; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr_at(input int edge_no, input int addr, input logic [31:0] data);
        while (cyc < edge_no - 1) @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops due items and compares
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at <= cyc) begin
                logic [31:0] act;
                exp_t e;
                e = q[i];
                act = '0;
                case (e.kind)
                    0: act = 32'(irq_o[e.core]);
                    1: act = 32'(nmi_o[e.core]);
                    2: act = 32'(soft_rst_o);
                    3: begin rd_addr = AW'(2 * e.core); #0.5; act = rd_data; end
                    default: begin rd_addr = AW'(e.core); #0.5; act = rd_data; end
                endcase
                checks++;
                if (e.at != cyc || act !== e.val) begin
                    errors++;
                    $display("FAIL %s: kind %0d core %0d due %0d at %0d actual %h expected %h",
                             e.tag, e.kind, e.core, e.at, cyc, act, e.val);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0;
        int p0;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        push(cyc + 1, 0, 0, 0, "R1 irq");
        push(cyc + 1, 1, 0, 0, "R1 nmi");
        push(cyc + 1, 2, 0, 0, "R1 soft reset");
        push(cyc + 1, 3, 0, 0, "R1 setup core0");
        push(cyc + 1, 3, 3, 0, "R1 setup core3");
        drain();

        // R2 R3 R4: full escalation, core0 len1 (32 clocks); core1 mode1 len3 (64 clocks)
        e0 = cyc + 1;
        push(e0 + 31, 0, 0, 0, "R2 early");
        push(e0 + 32, 0, 0, 1, "R2 on time");
        push(e0 + 63, 1, 0, 0, "R3 early");
        push(e0 + 64, 1, 0, 1, "R3 on time");
        push(e0 + 64, 3, 0, cfg(1, 3, 2), "R9 layout stage2");
        push(e0 + 95, 2, 0, 0, "R4 early");
        push(e0 + 96, 2, 0, 1, "R4 pulse");
        push(e0 + 96, 3, 0, cfg(1, 3, 3), "R4 stage3");
        push(e0 + 97, 2, 0, 0, "R4 pulse width");
        push(e0 + 97, 0, 0, 0, "R4 irq cleared");
        push(e0 + 97, 1, 0, 0, "R4 nmi cleared");
        push(e0 + 97, 3, 0, 0, "R4 setup cleared");
        push(e0 + 70, 0, 1, 1, "R5 mode1 irq");
        push(e0 + 95, 1, 1, 0, "R5 mode1 no nmi");
        push(e0 + 97, 0, 1, 0, "R4 other core cleared");
        push(e0 + 97, 3, 1, 0, "R4 other setup cleared");
        wr_at(e0, 0, cfg(1, 3));
        wr_at(e0 + 1, 2, cfg(3, 1));
        drain();

        // R5: mode1 holds at stage1, mode2 holds at stage2
        e0 = cyc + 1;
        push(e0 + 16, 0, 2, 1, "R5 mode1 irq");
        push(e0 + 40, 1, 2, 0, "R5 mode1 no nmi");
        push(e0 + 60, 1, 2, 0, "R5 mode1 no nmi late");
        push(e0 + 60, 3, 2, cfg(0, 1, 1), "R5 mode1 stage holds");
        push(e0 + 32, 1, 3, 0, "R5 mode2 nmi early");
        push(e0 + 33, 1, 3, 1, "R5 mode2 nmi");
        push(e0 + 49, 2, 0, 0, "R5 mode2 no reset");
        push(e0 + 81, 2, 0, 0, "R5 mode2 no reset late");
        push(e0 + 81, 3, 3, cfg(0, 2, 2), "R5 mode2 stage holds");
        wr_at(e0, 4, cfg(0, 1));
        wr_at(e0 + 1, 6, cfg(0, 2));
        drain();
        wr_at(cyc + 1, 4, 0);
        wr_at(cyc + 1, 6, 0);

        // R7 R10: service values and mid-period rewrite, len2 (48 clocks)
        e0 = cyc + 1;
        p0 = e0 + 50;
        w0 = p0 + 60;
        push(e0 + 47, 0, 0, 0, "R2 early len2");
        push(e0 + 48, 0, 0, 1, "R7 service 0 and 3 ignored");
        push(p0, 0, 0, 0, "R7 service drops irq");
        push(p0 + 47, 0, 0, 0, "R7 full period early");
        push(p0 + 48, 0, 0, 1, "R7 full period");
        push(e0 + 96, 1, 0, 0, "R7 progress cleared");
        push(w0, 0, 0, 0, "R10 rewrite drops irq");
        push(w0 + 47, 0, 0, 0, "R10 restart early");
        push(w0 + 48, 0, 0, 1, "R10 restart on time");
        push(w0 + 50, 0, 0, 0, "R6 disable drops irq");
        push(w0 + 50, 3, 0, 0, "R6 setup reads 0");
        push(w0 + 150, 2, 0, 0, "R6 no reset after disable");
        wr_at(e0, 0, cfg(2, 3));
        wr_at(e0 + 40, 1, 32'h0);
        wr_at(e0 + 41, 1, 32'h3);
        wr_at(p0, 1, 32'h1);
        wr_at(w0, 0, cfg(2, 3));
        wr_at(w0 + 50, 0, 0);
        drain();

        // R6: disable before expiry, and disable while raised
        e0 = cyc + 1;
        push(e0 + 16, 0, 1, 0, "R6 no irq");
        push(e0 + 40, 1, 1, 0, "R6 no nmi");
        push(e0 + 50, 2, 0, 0, "R6 no reset");
        push(e0 + 76, 0, 1, 1, "R2 len0 period");
        push(e0 + 80, 0, 1, 0, "R6 disable while raised");
        wr_at(e0, 2, cfg(0, 3));
        wr_at(e0 + 8, 2, 0);
        wr_at(e0 + 60, 2, cfg(0, 1));
        wr_at(e0 + 80, 2, 0);
        drain();

        // R8: independence of cores 0 and 1
        e0 = cyc + 1;
        push(e0 + 16, 0, 0, 1, "R8 core0 irq");
        push(e0 + 16, 0, 1, 0, "R8 core1 still counting");
        push(e0 + 20, 0, 0, 0, "R8 core0 serviced");
        push(e0 + 36, 0, 0, 1, "R8 core0 re-expires");
        push(e0 + 49, 0, 1, 1, "R8 core1 unaffected");
        push(e0 + 49, 1, 1, 0, "R8 core1 no nmi yet");
        push(e0 + 50, 4, 3, 0, "R9 service address reads 0");
        push(e0 + 52, 1, 0, 1, "R8 core0 nmi");
        push(e0 + 97, 1, 1, 1, "R8 core1 nmi");
        wr_at(e0, 0, cfg(0, 2));
        wr_at(e0 + 1, 2, cfg(2, 2));
        wr_at(e0 + 20, 1, 32'h1);
        drain();
        wr_at(cyc + 1, 0, 0);
        wr_at(cyc + 1, 2, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule